// File: doc/BRIEF.md
# Multiplexed Digit Scanner

This block takes a set of BCD digit values, five by default, and presents them one at a time on a single shared digit bus. A one-hot set of select lines shows which digit is on the bus, so a display driver can strobe one position while the bus carries that digit's value. On every clock edge where the step strobe is high, the scan moves on to the next digit. After the last digit it wraps back to the first.

A scan-reset input puts the scan on the last digit at once, in the same cycle it is raised, and holds it there. A skip input takes the first digit out of the rotation, so the cycle is one digit shorter. The digit bus and the select lines each have their own active-high float control. Each control is modelled as a data output plus an output enable. The data output reads zero while it is floated. The digit bus follows its selected input combinationally, so a change in a digit value shows without waiting for a step.

Top module: `digit_scanner`

## Requirements
- R1: While `sel_hiz` is low, exactly one bit of `sel_out` is high. Bit i marks digit i, and bit 0 is the first (least significant) digit.
- R2: While `bcd_hiz` is low, `bcd_out` equals the field of `digits_in` for the selected digit. Digit i occupies bits [4i+3:4i].
- R3: At a clock edge with `scan_step` high, the selection moves from digit i to digit i+1. At an edge with `scan_step` low, it stays where it is.
- R4: A step taken from the last digit moves the selection to digit 0, or to digit 1 when `skip_first` is high.
- R5: While `scan_rst` is high, the last digit is selected in that same cycle, and `scan_step` has no effect. After release, the next step goes to the first digit of the cycle.
- R6: While `skip_first` is high, digit 0 is never selected, and a continuous run of steps visits the digits in a cycle of four. If the scan is resting on digit 0 when `skip_first` rises, digit 1 is shown instead.
- R7: While `bcd_hiz` is high, `bcd_oe` is low and `bcd_out` is zero. The select lines and the scan position are not affected.
- R8: While `sel_hiz` is high, `sel_oe` is low and `sel_out` is zero. The digit bus and the scan position are not affected.
- R9: A change on `digits_in` appears on `bcd_out` in the same cycle, with no step needed.
- R10: With `rst_n` low at a clock edge (synchronous, active low), the scan position returns to the last digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_step | input | 1 | Advance the scan one digit at this edge |
| scan_rst | input | 1 | Force selection to the last digit, active high |
| skip_first | input | 1 | Remove digit 0 from the scan cycle |
| bcd_hiz | input | 1 | Float the digit bus, active high |
| sel_hiz | input | 1 | Float the select lines, active high |
| digits_in | input | NUM_DIGITS*DIGIT_W (20) | Packed digit values, digit 0 in the low bits |
| bcd_out | output | DIGIT_W (4) | Selected digit value, zero when floated |
| bcd_oe | output | 1 | Drive enable for the digit bus |
| sel_out | output | NUM_DIGITS (5) | One-hot digit select, zero when floated |
| sel_oe | output | 1 | Drive enable for the select lines |

## Verification
The bench builds the block with its defaults: five digits of four bits each. With these values, both wrap targets can be reached in a few dozen cycles. These are the full five-digit cycle and the shortened four-digit cycle. The bench also covers the corner where the skip input is raised while the scan rests on digit 0, and scan reset held across steps. Distinct values in every digit field let a wrong field offset show on the bus at once.

// File: rtl/scan_pkg.sv
// Package: shared constants and helpers for the digit scanner.
// Assumes at least two digits, so that a skip target exists.
package scan_pkg;

    // Smallest digit count for which the skip mode has meaning.
    localparam int unsigned SCAN_MIN_DIGITS = 2;

    // Returns the digit index that a step from the last digit lands on.
    function automatic int unsigned scan_wrap_target(input logic skip);
        return skip ? 1 : 0;
    endfunction

endpackage

// File: rtl/scan_position.sv
// scan_position: holds the registered scan position and derives the
// effective position that drives the outputs this cycle. Scan reset
// and the skip mode override the register combinationally. The next
// state is built from the effective position, so an override also
// commits to the register at the next edge.
// Assumes NUM_DIGITS >= 2.
module scan_position
    import scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 5,
    localparam int unsigned IDX_W = $clog2(NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_step,
    input  logic             scan_rst,
    input  logic             skip_first,
    output logic [IDX_W-1:0] eff_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);
    localparam logic [IDX_W-1:0] ALT_IDX  = IDX_W'(scan_wrap_target(1'b1));
    localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(scan_wrap_target(1'b0));

    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] pos_d;
    logic [IDX_W-1:0] wrap_idx;

    // Effective position: reset wins, then skip pushes off digit 0.
    always_comb begin
        if (scan_rst) begin
            eff_idx = LAST_IDX;
        end else if (skip_first && pos_q == HOME_IDX) begin
            eff_idx = ALT_IDX;
        end else if (pos_q > LAST_IDX) begin
            eff_idx = LAST_IDX;
        end else begin
            eff_idx = pos_q;
        end
    end

    // Wrap target after the last digit depends on the skip mode.
    always_comb begin
        wrap_idx = skip_first ? ALT_IDX : HOME_IDX;
    end

    // Next position: hold, or step with wrap; reset pins the last digit.
    always_comb begin
        if (scan_rst) begin
            pos_d = LAST_IDX;
        end else if (scan_step) begin
            pos_d = (eff_idx == LAST_IDX) ? wrap_idx : eff_idx + 1'b1;
        end else begin
            pos_d = eff_idx;
        end
    end

    // Position register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= LAST_IDX;
        end else begin
            pos_q <= pos_d;
        end
    end

endmodule

// File: rtl/scan_digit_mux.sv
// scan_digit_mux: turns the effective position into a one-hot select
// vector and picks the matching digit field from the packed input.
// Purely combinational, so digit updates show in the same cycle.
// Assumes digit i sits at bits [i*DIGIT_W +: DIGIT_W].
module scan_digit_mux #(
    parameter int unsigned NUM_DIGITS = 5,
    parameter int unsigned DIGIT_W    = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_DIGITS),
    localparam int unsigned BUS_W     = NUM_DIGITS * DIGIT_W
) (
    input  logic [IDX_W-1:0]      eff_idx,
    input  logic [BUS_W-1:0]      digits_in,
    output logic [NUM_DIGITS-1:0] sel_onehot,
    output logic [DIGIT_W-1:0]    digit_val
);

    // One decoder bit per digit position.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
        assign sel_onehot[g] = (eff_idx == IDX_W'(g));
    end

    // Field select: AND-OR of each field with its decode bit.
    always_comb begin
        digit_val = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            digit_val = digit_val
                      | (digits_in[i*DIGIT_W +: DIGIT_W] & {DIGIT_W{sel_onehot[i]}});
        end
    end

endmodule

// File: rtl/scan_out_gate.sv
// scan_out_gate: models one float-capable output group as a data value
// plus an enable. When the float control is high, the enable drops and
// the data reads zero. Independent instances serve each group.
module scan_out_gate #(
    parameter int unsigned W = 4
) (
    input  logic         hiz,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] data_out,
    output logic         oe
);

    // Enable is the inverse of the float control; data is masked by it.
    always_comb begin
        oe       = ~hiz;
        data_out = data_in & {W{~hiz}};
    end

endmodule

// File: rtl/digit_scanner.sv
// digit_scanner: top of the multiplexed digit scanner. It steps a
// position through the digits, shows the chosen digit on a shared bus
// with a one-hot select, and gates both groups through float controls.
// Assumes NUM_DIGITS >= 2 and that scan_step is a clock-enable strobe.
module digit_scanner
    import scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 5,
    parameter int unsigned DIGIT_W    = 4,
    localparam int unsigned IDX_W     = $clog2(NUM_DIGITS),
    localparam int unsigned BUS_W     = NUM_DIGITS * DIGIT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_step,
    input  logic                  scan_rst,
    input  logic                  skip_first,
    input  logic                  bcd_hiz,
    input  logic                  sel_hiz,
    input  logic [BUS_W-1:0]      digits_in,
    output logic [DIGIT_W-1:0]    bcd_out,
    output logic                  bcd_oe,
    output logic [NUM_DIGITS-1:0] sel_out,
    output logic                  sel_oe
);

    logic [IDX_W-1:0]      eff_idx;
    logic [NUM_DIGITS-1:0] sel_onehot;
    logic [DIGIT_W-1:0]    digit_val;

    scan_position #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_step  (scan_step),
        .scan_rst   (scan_rst),
        .skip_first (skip_first),
        .eff_idx    (eff_idx)
    );

    scan_digit_mux #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIGIT_W    (DIGIT_W)
    ) u_mux (
        .eff_idx    (eff_idx),
        .digits_in  (digits_in),
        .sel_onehot (sel_onehot),
        .digit_val  (digit_val)
    );

    scan_out_gate #(
        .W (DIGIT_W)
    ) u_bcd_gate (
        .hiz      (bcd_hiz),
        .data_in  (digit_val),
        .data_out (bcd_out),
        .oe       (bcd_oe)
    );

    scan_out_gate #(
        .W (NUM_DIGITS)
    ) u_sel_gate (
        .hiz      (sel_hiz),
        .data_in  (sel_onehot),
        .data_out (sel_out),
        .oe       (sel_oe)
    );

endmodule

// File: rtl/digit_scanner_chk.sv
// digit_scanner_chk: port-level properties of the digit scanner,
// bound to every instance of digit_scanner.
module digit_scanner_chk #(
    parameter int unsigned NUM_DIGITS = 5,
    parameter int unsigned DIGIT_W    = 4,
    localparam int unsigned BUS_W     = NUM_DIGITS * DIGIT_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_step,
    input logic                  scan_rst,
    input logic                  skip_first,
    input logic                  bcd_hiz,
    input logic                  sel_hiz,
    input logic [BUS_W-1:0]      digits_in,
    input logic [DIGIT_W-1:0]    bcd_out,
    input logic                  bcd_oe,
    input logic [NUM_DIGITS-1:0] sel_out,
    input logic                  sel_oe
);

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_oe |-> $countones(sel_out) == 1);

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && !scan_step && !scan_rst && !skip_first)
        |=> (!sel_oe || scan_rst || skip_first || sel_out == $past(sel_out)));

    // R4
    wrap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && sel_out[NUM_DIGITS-1] && scan_step && !scan_rst)
        |=> (!sel_oe || scan_rst || sel_out[0] || sel_out[1]));

    // R5
    scan_rst_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_rst && sel_oe) |-> sel_out[NUM_DIGITS-1]);

    // R6
    skip_no_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_first && sel_oe) |-> !sel_out[0]);

    // R7
    bcd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_hiz |-> (!bcd_oe && bcd_out == '0));

    // R8
    sel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hiz |-> (!sel_oe && sel_out == '0));

    // R7
    bcd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bcd_hiz |-> bcd_oe);

endmodule

bind digit_scanner digit_scanner_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .DIGIT_W    (DIGIT_W)
) u_chk (.*);

// File: tb/digit_scanner_tb.sv
// digit_scanner_tb: behavioural reference of the scan position, compared
// with the outputs at every falling clock edge.
module digit_scanner_tb;

    localparam int N  = 5;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          scan_step;
    logic          scan_rst;
    logic          skip_first;
    logic          bcd_hiz;
    logic          sel_hiz;
    logic [N*DW-1:0] digits_in;
    logic [DW-1:0] bcd_out;
    logic          bcd_oe;
    logic [N-1:0]  sel_out;
    logic          sel_oe;

    int total = 0;
    int bad   = 0;
    int m_pos = N - 1;
    bit live  = 1'b0;
    string phase = "R10";

    always #5 clk = ~clk;

    digit_scanner u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_step  (scan_step),
        .scan_rst   (scan_rst),
        .skip_first (skip_first),
        .bcd_hiz    (bcd_hiz),
        .sel_hiz    (sel_hiz),
        .digits_in  (digits_in),
        .bcd_out    (bcd_out),
        .bcd_oe     (bcd_oe),
        .sel_out    (sel_out),
        .sel_oe     (sel_oe)
    );

    // Position shown this cycle, per R5 and R6.
    function automatic int shown(input int p);
        if (scan_rst) return N - 1;
        if (skip_first && p == 0) return 1;
        return p;
    endfunction

    // Reference step at every rising edge (R3, R4, R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos <= N - 1;
            live  <= 1'b1;
        end else begin
            int e;
            e = shown(m_pos);
            if (scan_rst)           m_pos <= N - 1;
            else if (!scan_step)    m_pos <= e;
            else if (e == N - 1)    m_pos <= skip_first ? 1 : 0;
            else                    m_pos <= e + 1;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Full output comparison on every falling edge.
    always @(negedge clk) begin
        if (live && rst_n) begin
            logic [N-1:0]  es;
            logic [DW-1:0] eb;
            int e;
            e  = shown(m_pos);
            es = sel_hiz ? '0 : N'(1 << e);
            eb = bcd_hiz ? '0 : digits_in[e*DW +: DW];
            check(sel_out == es && sel_oe == !sel_hiz, {phase, " sel"},
                  {sel_oe, sel_out}, {!sel_hiz, es});
            check(bcd_out == eb && bcd_oe == !bcd_hiz, {phase, " bcd"},
                  {bcd_oe, bcd_out}, {!bcd_hiz, eb});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        rst_n = 1'b0; scan_step = 1'b1; scan_rst = 1'b0; skip_first = 1'b0;
        bcd_hiz = 1'b0; sel_hiz = 1'b0;
        digits_in = 20'h97531;
        cyc(3);
        // R10: reset leaves the last digit selected, despite step high.
        rst_n = 1'b1; scan_step = 1'b0;
        @(negedge clk);
        check(sel_out == 5'b10000, "R10 reset state", sel_out, 5'b10000);
        check(bcd_out == 4'h9, "R2 reset digit", bcd_out, 4'h9);
        #1;

        // R3 R4 R2: continuous stepping, full five-digit cycle.
        phase = "R3/R4 step";
        scan_step = 1'b1;
        cyc(1);
        @(negedge clk);
        check(sel_out == 5'b00001, "R4 wrap to digit0", sel_out, 5'b00001);
        check(bcd_out == 4'h1, "R2 digit0 field", bcd_out, 4'h1);
        #1;
        cyc(11);

        // R3: hold while step is low; R9 live digit updates.
        phase = "R3 hold";
        scan_step = 1'b0;
        cyc(3);
        phase = "R9 live update";
        for (int k = 0; k < 4; k++) begin
            digits_in = digits_in + 20'h11111;
            @(negedge clk);
            #1;
        end
        digits_in = 20'h48260;
        cyc(2);

        // R5: scan reset with step high, held for several cycles.
        phase = "R5 scan reset";
        scan_step = 1'b1;
        cyc(2);
        scan_rst = 1'b1;
        @(negedge clk);
        check(sel_out == 5'b10000, "R5 immediate last", sel_out, 5'b10000);
        #1;
        cyc(3);
        scan_rst = 1'b0;
        @(negedge clk);
        check(sel_out == 5'b10000, "R5 after release", sel_out, 5'b10000);
        #1;
        cyc(1);
        @(negedge clk);
        check(sel_out == 5'b00001, "R5 next step first", sel_out, 5'b00001);
        #1;

        // R6: skip raised while resting on digit 0.
        phase = "R6 skip";
        scan_step = 1'b0;
        skip_first = 1'b1;
        @(negedge clk);
        check(sel_out == 5'b00010, "R6 skip from rest", sel_out, 5'b00010);
        #1;
        scan_step = 1'b1;
        cyc(12);
        scan_step = 1'b0;
        scan_rst = 1'b1;
        cyc(1);
        scan_rst = 1'b0;
        scan_step = 1'b1;
        cyc(1);
        @(negedge clk);
        check(sel_out == 5'b00010, "R6 wrap to digit1", sel_out, 5'b00010);
        #1;
        cyc(4);
        @(negedge clk);
        check(sel_out == 5'b00010, "R6 four-digit cycle", sel_out, 5'b00010);
        #1;
        skip_first = 1'b0;

        // R7: float the digit bus while stepping.
        phase = "R7 bcd float";
        bcd_hiz = 1'b1;
        cyc(6);
        @(negedge clk);
        check(bcd_out == 4'h0 && !bcd_oe, "R7 bcd floated", {bcd_oe, bcd_out}, 5'h0);
        check(sel_oe == 1'b1, "R7 sel unaffected", sel_oe, 1'b1);
        #1;
        bcd_hiz = 1'b0;

        // R8: float the select lines while stepping.
        phase = "R8 sel float";
        sel_hiz = 1'b1;
        cyc(7);
        @(negedge clk);
        check(sel_out == '0 && !sel_oe, "R8 sel floated", {sel_oe, sel_out}, 6'h0);
        #1;
        bcd_hiz = 1'b1;
        cyc(3);
        bcd_hiz = 1'b0;
        sel_hiz = 1'b0;

        // R1: pseudo-random mix of every control.
        phase = "R1 mix";
        lfsr = 8'hA5;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            scan_step  = lfsr[0] | lfsr[3];
            scan_rst   = (lfsr[7:5] == 3'b111);
            skip_first = lfsr[6] & lfsr[2];
            bcd_hiz    = (lfsr[4:1] == 4'hF);
            sel_hiz    = (lfsr[5:2] == 4'h0);
            digits_in  = {lfsr[3:0], lfsr, lfsr};
            cyc(1);
        end
        scan_rst = 1'b0; skip_first = 1'b0; bcd_hiz = 1'b0; sel_hiz = 1'b0;

        // R10: synchronous reset in mid-scan.
        phase = "R10 mid reset";
        scan_step = 1'b1;
        cyc(2);
        rst_n = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        scan_step = 1'b0;
        @(negedge clk);
        check(sel_out == 5'b10000, "R10 mid-scan reset", sel_out, 5'b10000);
        #1;
        cyc(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule